// File: doc/BRIEF.md
# Per-Stream Size Filter with Sticky Oversize Block

This block sits between stream identification and stream gating. Each identified frame arrives with the index of its filter entry and its length. The block looks up the entry and passes on the entry's stream gate index. It also makes a pass or drop decision based on a per-entry maximum service data unit (SDU) size.

An entry can be told to remember an oversize violation. When that option is on and a frame longer than the entry's limit arrives, the entry latches a blocked flag. From then on every frame mapped to that entry is dropped until software rewrites the entry.

A configuration port writes and reads whole entries. Writing an entry with all fields zero is how a filter is removed. Frame results and configuration read data each appear one clock cycle after the request.

Top module: `strm_filter`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` and `cfg_rvalid` are 0 and every entry reads back as gate 0, size limit 0, block enable 0 and block flag 0.
- R2: A configuration write stores the gate index, size limit, block enable and block flag of the addressed entry. A read of that entry returns those four values on `cfg_r*`, with `cfg_rvalid` high, in the cycle after `cfg_re`.
- R3: A frame presented with `frm_valid` yields `res_valid` high in the next cycle, with `res_gate` equal to the gate index held by the addressed entry.
- R4: A frame whose length is strictly greater than a nonzero size limit gets `res_drop`=1. A frame whose length equals or is below the limit, on an unblocked entry, gets `res_drop`=0.
- R5: A size limit of 0 disables the size check: on an unblocked entry any length passes and no block flag is latched.
- R6: When an oversize frame hits an entry whose block enable is 1, that entry's block flag becomes 1. While the flag is 1, whether it was latched or written, every frame on that entry is dropped regardless of length.
- R7: An oversize frame on an entry whose block enable is 0 is dropped but leaves the block flag at 0, so later frames within the limit pass.
- R8: Rewriting an entry with block flag 0 clears a latched block, and later in-limit frames pass.
- R9: If a configuration write and a frame lookup address the same entry in the same cycle, the entry takes the written value and any flag the frame would have latched is discarded. The frame's own decision uses the entry contents from before the write.
- R10: An entry written with all fields zero reads back as zero and passes any frame with gate index 0.
- R11: A latched block flag affects only its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | Frame lookup request |
| frm_idx | input | IDX_W | Filter entry index of the frame |
| frm_len | input | 16 | Frame length in bytes |
| res_valid | output | 1 | Frame result valid (one cycle after request) |
| res_gate | output | 10 | Stream gate index for the frame |
| res_drop | output | 1 | 1 = drop the frame |
| cfg_we | input | 1 | Entry write strobe |
| cfg_re | input | 1 | Entry read strobe |
| cfg_idx | input | IDX_W | Entry index for read or write |
| cfg_wgate | input | 10 | Gate index to write |
| cfg_wsdu | input | 16 | Size limit to write (0 = no limit) |
| cfg_wblk_en | input | 1 | Block enable to write |
| cfg_wblk_state | input | 1 | Block flag to write |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rgate | output | 10 | Read gate index |
| cfg_rsdu | output | 16 | Read size limit |
| cfg_rblk_en | output | 1 | Read block enable |
| cfg_rblk_state | output | 1 | Read block flag |

## Verification
The bench builds the block with 16 entries instead of 1024, so IDX_W is 4. The first and last indices can then be reached by a few writes, and one entry's blocked state can be observed not to leak into its neighbours. Gate and size widths keep their full 10 and 16 bits. This puts the all-ones gate index, the 16-bit maximum length and the exact-limit length within the directed cases.

// File: rtl/strm_filter_pkg.sv
// Package: shared field widths and entry layout for the stream filter.
// Assumes the gate index and size limit widths are fixed chip-wide.
package strm_filter_pkg;
    localparam int unsigned SF_GATE_W = 10;
    localparam int unsigned SF_SDU_W  = 16;

    typedef struct packed {
        logic [SF_GATE_W-1:0] gate;
        logic [SF_SDU_W-1:0]  max_sdu;
        logic                 blk_en;
        logic                 blk_state;
    } sf_entry_t;
endpackage

// File: rtl/strm_filter_table.sv
// Module: entry storage for the stream filter.
// Provides one frame-side read port, one config read port, one config
// write port and a sticky-flag set port. A write to the same entry in
// the same cycle as a flag set wins. Reset zeroes every entry.
module strm_filter_table
    import strm_filter_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 1024,
    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  sf_entry_t        wdata,
    input  logic             set_req,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] fidx,
    output sf_entry_t        fentry,
    input  logic [IDX_W-1:0] cidx,
    output sf_entry_t        centry
);
    sf_entry_t mem [NUM_ENTRIES];
    logic      set_blocked;

    // Write collision: the config write suppresses the sticky set.
    always_comb set_blocked = we && (widx == set_idx);

    // Storage update: reset clears, config writes, sticky flag latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (we) begin
                mem[widx] <= wdata;
            end
            if (set_req && !set_blocked) begin
                mem[set_idx].blk_state <= 1'b1;
            end
        end
    end

    // Asynchronous read ports for frame and config sides.
    always_comb fentry = mem[fidx];
    always_comb centry = mem[cidx];

    // R6: a sticky set without a colliding write leaves the flag at 1
    a_r6_sticky_latch: assert property (@(posedge clk) disable iff (!rst_n)
        set_req && !(we && widx == set_idx) |=> mem[$past(set_idx)].blk_state);

    // R9: on collision the stored entry is exactly the written value
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        we && set_req && (widx == set_idx) |=> mem[$past(widx)] == $past(wdata));

    // R2: a plain write is stored as given
    a_r2_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
        we && !set_req |=> mem[$past(widx)] == $past(wdata));
endmodule

// File: rtl/strm_filter_decide.sv
// Module: combinational pass/drop decision for one frame.
// Assumes the entry is the current contents for the frame's index.
// A size limit of zero means no limit.
module strm_filter_decide
    import strm_filter_pkg::*;
(
    input  sf_entry_t             entry,
    input  logic [SF_SDU_W-1:0]   len,
    output logic                  drop,
    output logic                  set_block
);
    logic over;

    // Oversize detect: only against a nonzero limit.
    always_comb over = (entry.max_sdu != '0) && (len > entry.max_sdu);

    // Decision: blocked or oversize drops; enabled oversize asks to latch.
    always_comb begin
        drop      = entry.blk_state || over;
        set_block = over && entry.blk_en;
    end
endmodule

// File: rtl/strm_filter.sv
// Module: per-stream size filter with sticky oversize block (top).
// Frame results and config read data are registered, one cycle after
// the request. Assumes at most one frame lookup per cycle.
module strm_filter
    import strm_filter_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 1024,
    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid,
    input  logic [IDX_W-1:0]     frm_idx,
    input  logic [SF_SDU_W-1:0]  frm_len,
    output logic                 res_valid,
    output logic [SF_GATE_W-1:0] res_gate,
    output logic                 res_drop,
    input  logic                 cfg_we,
    input  logic                 cfg_re,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [SF_GATE_W-1:0] cfg_wgate,
    input  logic [SF_SDU_W-1:0]  cfg_wsdu,
    input  logic                 cfg_wblk_en,
    input  logic                 cfg_wblk_state,
    output logic                 cfg_rvalid,
    output logic [SF_GATE_W-1:0] cfg_rgate,
    output logic [SF_SDU_W-1:0]  cfg_rsdu,
    output logic                 cfg_rblk_en,
    output logic                 cfg_rblk_state
);
    sf_entry_t wdata;
    sf_entry_t fentry;
    sf_entry_t centry;
    logic      drop;
    logic      set_block;

    // Pack the config write fields into an entry.
    always_comb begin
        wdata.gate      = cfg_wgate;
        wdata.max_sdu   = cfg_wsdu;
        wdata.blk_en    = cfg_wblk_en;
        wdata.blk_state = cfg_wblk_state;
    end

    strm_filter_table #(.NUM_ENTRIES(NUM_ENTRIES)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .widx    (cfg_idx),
        .wdata   (wdata),
        .set_req (frm_valid && set_block),
        .set_idx (frm_idx),
        .fidx    (frm_idx),
        .fentry  (fentry),
        .cidx    (cfg_idx),
        .centry  (centry)
    );

    strm_filter_decide i_decide (
        .entry     (fentry),
        .len       (frm_len),
        .drop      (drop),
        .set_block (set_block)
    );

    // Frame result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_gate  <= '0;
            res_drop  <= 1'b0;
        end else begin
            res_valid <= frm_valid;
            res_gate  <= frm_valid ? fentry.gate : '0;
            res_drop  <= frm_valid && drop;
        end
    end

    // Config read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid     <= 1'b0;
            cfg_rgate      <= '0;
            cfg_rsdu       <= '0;
            cfg_rblk_en    <= 1'b0;
            cfg_rblk_state <= 1'b0;
        end else begin
            cfg_rvalid     <= cfg_re;
            cfg_rgate      <= centry.gate;
            cfg_rsdu       <= centry.max_sdu;
            cfg_rblk_en    <= centry.blk_en;
            cfg_rblk_state <= centry.blk_state;
        end
    end

    // R3: every lookup yields a result in the next cycle
    a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);

    // R3: the result carries the gate index of the looked-up entry
    a_r3_gate_passed: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_gate == $past(fentry.gate));

    // R4: an oversize frame against a nonzero limit is dropped
    a_r4_oversize_drop: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && fentry.max_sdu != '0 && frm_len > fentry.max_sdu |=> res_drop);

    // R5: zero limit on an unblocked entry never drops
    a_r5_no_limit_pass: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && fentry.max_sdu == '0 && !fentry.blk_state |=> !res_drop);

    // R6: a blocked entry drops every frame
    a_r6_blocked_drop: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && fentry.blk_state |=> res_drop);
endmodule

// File: tb/test_strm_filter.sv
module test_strm_filter;
    localparam int unsigned N     = 16;
    localparam int unsigned IDX_W = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frm_valid = 1'b0;
    logic [IDX_W-1:0]  frm_idx = '0;
    logic [15:0]       frm_len = '0;
    logic              res_valid;
    logic [9:0]        res_gate;
    logic              res_drop;
    logic              cfg_we = 1'b0;
    logic              cfg_re = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [9:0]        cfg_wgate = '0;
    logic [15:0]       cfg_wsdu = '0;
    logic              cfg_wblk_en = 1'b0;
    logic              cfg_wblk_state = 1'b0;
    logic              cfg_rvalid;
    logic [9:0]        cfg_rgate;
    logic [15:0]       cfg_rsdu;
    logic              cfg_rblk_en;
    logic              cfg_rblk_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    strm_filter #(.NUM_ENTRIES(N)) i_strm_filter (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int gate, input int sdu, input bit en, input bit st);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[IDX_W-1:0];
        cfg_wgate = gate[9:0]; cfg_wsdu = sdu[15:0];
        cfg_wblk_en = en; cfg_wblk_state = st;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int idx, input int gate, input int sdu, input bit en,
                      input bit st, input string req);
        @(negedge clk);
        cfg_re = 1'b1; cfg_idx = idx[IDX_W-1:0];
        @(negedge clk);
        cfg_re = 1'b0;
        check(cfg_rvalid == 1'b1, req, "rvalid", 32'(cfg_rvalid), 1);
        check(cfg_rgate == gate[9:0], req, "rgate", 32'(cfg_rgate), 32'(gate));
        check(cfg_rsdu == sdu[15:0], req, "rsdu", 32'(cfg_rsdu), 32'(sdu));
        check(cfg_rblk_en == en, req, "rblk_en", 32'(cfg_rblk_en), 32'(en));
        check(cfg_rblk_state == st, req, "rblk_state", 32'(cfg_rblk_state), 32'(st));
    endtask

    task automatic frame(input int idx, input int len, input int gate, input bit drop,
                         input string req);
        @(negedge clk);
        frm_valid = 1'b1; frm_idx = idx[IDX_W-1:0]; frm_len = len[15:0];
        @(negedge clk);
        frm_valid = 1'b0;
        check(res_valid == 1'b1, req, "res_valid", 32'(res_valid), 1);
        check(res_gate == gate[9:0], req, "res_gate", 32'(res_gate), 32'(gate));
        check(res_drop == drop, req, "res_drop", 32'(res_drop), 32'(drop));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1", "res_valid in reset", 32'(res_valid), 0);
        check(cfg_rvalid == 1'b0, "R1", "cfg_rvalid in reset", 32'(cfg_rvalid), 0);
        rst_n = 1'b1;
        rd(5, 0, 0, 0, 0, "R1");
        rd(N - 1, 0, 0, 0, 0, "R1");
    endtask

    task automatic t_write_read();
        wr(2, 'h155, 100, 0, 0);
        rd(2, 'h155, 100, 0, 0, "R2");
        wr(N - 1, 'h3FF, 'hFFFF, 1, 0);
        rd(N - 1, 'h3FF, 'hFFFF, 1, 0, "R2");
        wr(0, 'h001, 1, 1, 1);
        rd(0, 'h001, 1, 1, 1, "R2");
    endtask

    task automatic t_size();
        frame(2, 50, 'h155, 0, "R3");
        frame(2, 100, 'h155, 0, "R4");
        frame(2, 101, 'h155, 1, "R4");
        frame(2, 60, 'h155, 0, "R7");
        rd(2, 'h155, 100, 0, 0, "R7");
        frame(N - 1, 'hFFFF, 'h3FF, 0, "R4");
    endtask

    task automatic t_zero_limit();
        wr(4, 7, 0, 1, 0);
        frame(4, 'hFFFF, 7, 0, "R5");
        rd(4, 7, 0, 1, 0, "R5");
    endtask

    task automatic t_sticky();
        wr(6, 9, 64, 1, 0);
        frame(6, 64, 9, 0, "R4");
        frame(6, 65, 9, 1, "R6");
        rd(6, 9, 64, 1, 1, "R6");
        frame(6, 10, 9, 1, "R6");
        frame(2, 10, 'h155, 0, "R11");
        frame(4, 10, 7, 0, "R11");
        wr(8, 3, 0, 0, 1);
        frame(8, 1, 3, 1, "R6");
    endtask

    task automatic t_clear();
        wr(6, 9, 64, 1, 0);
        rd(6, 9, 64, 1, 0, "R8");
        frame(6, 10, 9, 0, "R8");
    endtask

    task automatic t_collision();
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd6; cfg_wgate = 10'd12; cfg_wsdu = 16'd64;
        cfg_wblk_en = 1'b1; cfg_wblk_state = 1'b0;
        frm_valid = 1'b1; frm_idx = 4'd6; frm_len = 16'd200;
        @(negedge clk);
        cfg_we = 1'b0; frm_valid = 1'b0;
        check(res_drop == 1'b1, "R9", "collision frame drop", 32'(res_drop), 1);
        check(res_gate == 10'd9, "R9", "collision frame gate (old)", 32'(res_gate), 9);
        rd(6, 12, 64, 1, 0, "R9");
        frame(6, 10, 12, 0, "R9");
    endtask

    task automatic t_delete();
        wr(2, 0, 0, 0, 0);
        rd(2, 0, 0, 0, 0, "R10");
        frame(2, 5000, 0, 0, "R10");
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_size();
        t_zero_limit();
        t_sticky();
        t_clear();
        t_collision();
        t_delete();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule